// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This block sits beside one UART channel and decides, cycle by cycle, whether its transmitter may start another character. Two sources can pause the transmitter: the modem clear-to-send line (used as an active-low pin, so a high level asks the local side to stop) and an in-band stop code received from the far end. A pause never cuts a character short. When the transmitter is busy, the gate closes only when the current stop bit has gone out. When it is idle, the gate closes at once.

The same block watches the local receive FIFO fill level. It drives the request-to-send line with hysteresis, and it asks the transmitter to send a single stop code or resume code when the level crosses its thresholds. Each received byte is compared with four programmable codes: two resume codes and two stop codes. In software flow mode, bytes that match a flow code are taken out of the data stream. A separate special-character mode treats the second stop code as a marker. A marker byte is still stored and raises a flag, and it does not pause anything.

Top module: `flow_ctl`

## Requirements
- R1: With automatic CTS enabled and `cts_n` high, `tx_allow` falls one cycle after a clock edge at which either `tx_busy` is 0 or `tx_char_done` is 1, and at no other time while `tx_busy` is 1.
- R2: When every stop condition is gone (`cts_n` low or automatic CTS disabled, and no stop code held), `tx_allow` returns to 1 one cycle later.
- R3: `cts_irq` is a one-cycle pulse, issued the cycle after `cts_n` is first sampled high following a low sample, only while `cts_int_en` is 1.
- R4: With `sw_flow_en` set, a received stop code halts transmission at the next character boundary. The stop codes are `xoff1`, plus `xoff2` when special mode is off. A received resume code (`xon1` or `xon2`) releases the halt.
- R5: With `sw_flow_en` set, any byte that acts as a flow code does not appear on `rx_store`. Every other valid byte, and every byte while `sw_flow_en` is 0, is presented on `rx_store`/`rx_store_data` one cycle after `rx_valid`.
- R6: With `spec_char_en` set, a byte equal to `xoff2` is stored, pulses `spec_irq` one cycle after `rx_valid`, and causes no halt.
- R7: A match needs all 8 bits to be equal. Bit 0 of each code register is compared with bit 0 of the received byte.
- R8: With `auto_rts_en` set, `rts_ready` goes to 0 once `rx_count >= rx_trigger`, and goes back to 1 only once `rx_count < rx_trigger/2`. Between the two levels it holds its value. With `auto_rts_en` clear, it is 1.
- R9: With `sw_flow_en` set, `send_xoff` pulses once when the fill level reaches the trigger. `send_xon` pulses once after the level drops below half the trigger. The two never pulse together.
- R10: After reset, `tx_allow` and `rts_ready` are 1, and all pulses and `rx_store` are 0.
- R11: Clearing `sw_flow_en` drops any held stop code, so `tx_allow` returns to 1 (subject to CTS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_rts_en | input | 1 | Enable automatic RTS from FIFO level |
| auto_cts_en | input | 1 | Enable automatic pause on CTS |
| sw_flow_en | input | 1 | Enable in-band stop/resume codes |
| spec_char_en | input | 1 | Treat `xoff2` as a stored marker character |
| cts_int_en | input | 1 | Enable the CTS rise interrupt pulse |
| xon1 | input | 8 | First resume code |
| xon2 | input | 8 | Second resume code |
| xoff1 | input | 8 | First stop code |
| xoff2 | input | 8 | Second stop code / special marker |
| rx_byte | input | 8 | Received character |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| rx_count | input | 6 | Receive FIFO fill level |
| rx_trigger | input | 6 | Receive FIFO trigger level |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_char_done | input | 1 | Stop bit of the current character finished |
| cts_n | input | 1 | Clear-to-send, high means pause |
| tx_allow | output | 1 | Transmitter may start a character |
| rts_ready | output | 1 | Request-to-send, 1 means ready to receive |
| send_xon | output | 1 | Pulse: transmit a resume code |
| send_xoff | output | 1 | Pulse: transmit a stop code |
| rx_store | output | 1 | Write `rx_store_data` to the receive FIFO |
| rx_store_data | output | 8 | Byte to store |
| cts_irq | output | 1 | Pulse: CTS rose |
| spec_irq | output | 1 | Pulse: special marker received |

## Verification
The sharpest overlap is a stop code arriving in the very cycle the transmitter reports the end of a stop bit. The matched code must close the gate at that same boundary rather than one character later. The bench sets `tx_busy`, drives the stop byte together with `tx_char_done`, and expects `tx_allow` low on the next edge. A second overlap is a CTS rise on a busy transmitter. There the interrupt pulse must appear at once, while the gate stays open until the character-done strobe. Both are judged at the ports, one cycle after the deciding edge.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int DATA_W = 8;
  localparam int NCODES = 4;

  typedef enum logic [1:0] {
    CODE_XON1  = 2'd0,
    CODE_XON2  = 2'd1,
    CODE_XOFF1 = 2'd2,
    CODE_XOFF2 = 2'd3
  } code_idx_e;

  typedef struct packed {
    logic resume;
    logic halt;
    logic marker;
  } match_t;
endpackage

// File: rtl/fc_char_match.sv
module fc_char_match
  import fc_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] rx_byte,
  input  logic [W-1:0] xon1,
  input  logic [W-1:0] xon2,
  input  logic [W-1:0] xoff1,
  input  logic [W-1:0] xoff2,
  input  logic         spec_char_en,
  output match_t       hit
);
  logic [W-1:0]      codes [NCODES];
  logic [NCODES-1:0] eq;

  assign codes[CODE_XON1]  = xon1;
  assign codes[CODE_XON2]  = xon2;
  assign codes[CODE_XOFF1] = xoff1;
  assign codes[CODE_XOFF2] = xoff2;

  for (genvar i = 0; i < NCODES; i++) begin : g_cmp
    assign eq[i] = (rx_byte == codes[i]);
  end

  always_comb begin
    hit.marker = spec_char_en & eq[CODE_XOFF2];
    hit.halt   = eq[CODE_XOFF1] | (eq[CODE_XOFF2] & ~spec_char_en);
    hit.resume = eq[CODE_XON1] | eq[CODE_XON2];
  end
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic tx_busy,
  input  logic tx_char_done,
  output logic tx_allow
);
  logic at_boundary;
  assign at_boundary = ~tx_busy | tx_char_done;

  always_ff @(posedge clk) begin
    if (rst)
      tx_allow <= 1'b1;
    else if (!stop_req)
      tx_allow <= 1'b1;
    else if (at_boundary)
      tx_allow <= 1'b0;
  end
endmodule

// File: rtl/fc_rx_level.sv
module fc_rx_level #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_rts_en,
  input  logic             sw_flow_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trigger,
  output logic             rts_ready,
  output logic             send_xon,
  output logic             send_xoff
);
  logic [CNT_W-1:0] resume_lvl;
  logic             above, below, paused_far;

  assign resume_lvl = rx_trigger >> 1;
  assign above      = (rx_count >= rx_trigger);
  assign below      = (rx_count < resume_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_ready <= 1'b1;
    end else if (!auto_rts_en) begin
      rts_ready <= 1'b1;
    end else if (above) begin
      rts_ready <= 1'b0;
    end else if (below) begin
      rts_ready <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sw_flow_en) begin
      paused_far <= 1'b0;
      send_xon   <= 1'b0;
      send_xoff  <= 1'b0;
    end else begin
      send_xon  <= 1'b0;
      send_xoff <= 1'b0;
      if (!paused_far && above) begin
        send_xoff  <= 1'b1;
        paused_far <= 1'b1;
      end else if (paused_far && below) begin
        send_xon   <= 1'b1;
        paused_far <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flow_ctl.sv
module flow_ctl
  import fc_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             sw_flow_en,
  input  logic             spec_char_en,
  input  logic             cts_int_en,
  input  logic [W-1:0]     xon1,
  input  logic [W-1:0]     xon2,
  input  logic [W-1:0]     xoff1,
  input  logic [W-1:0]     xoff2,
  input  logic [W-1:0]     rx_byte,
  input  logic             rx_valid,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trigger,
  input  logic             tx_busy,
  input  logic             tx_char_done,
  input  logic             cts_n,
  output logic             tx_allow,
  output logic             rts_ready,
  output logic             send_xon,
  output logic             send_xoff,
  output logic             rx_store,
  output logic [W-1:0]     rx_store_data,
  output logic             cts_irq,
  output logic             spec_irq
);
  match_t hit;
  logic   halt_held, halt_next, stop_req, cts_q, consume;

  fc_char_match #(.W(W)) u_match (
    .rx_byte(rx_byte), .xon1(xon1), .xon2(xon2), .xoff1(xoff1),
    .xoff2(xoff2), .spec_char_en(spec_char_en), .hit(hit)
  );

  always_comb begin
    halt_next = halt_held;
    if (!sw_flow_en)
      halt_next = 1'b0;
    else if (rx_valid && hit.halt)
      halt_next = 1'b1;
    else if (rx_valid && hit.resume)
      halt_next = 1'b0;
  end

  assign consume  = sw_flow_en & (hit.halt | hit.resume);
  assign stop_req = (auto_cts_en & cts_n) | halt_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_held     <= 1'b0;
      cts_q         <= 1'b0;
      cts_irq       <= 1'b0;
      spec_irq      <= 1'b0;
      rx_store      <= 1'b0;
      rx_store_data <= '0;
    end else begin
      halt_held <= halt_next;
      cts_q     <= cts_n;
      cts_irq   <= cts_int_en & cts_n & ~cts_q;
      spec_irq  <= rx_valid & hit.marker;
      rx_store  <= rx_valid & ~consume;
      if (rx_valid)
        rx_store_data <= rx_byte;
    end
  end

  fc_tx_gate u_gate (
    .clk(clk), .rst(rst), .stop_req(stop_req), .tx_busy(tx_busy),
    .tx_char_done(tx_char_done), .tx_allow(tx_allow)
  );

  fc_rx_level #(.CNT_W(CNT_W)) u_level (
    .clk(clk), .rst(rst), .auto_rts_en(auto_rts_en), .sw_flow_en(sw_flow_en),
    .rx_count(rx_count), .rx_trigger(rx_trigger), .rts_ready(rts_ready),
    .send_xon(send_xon), .send_xoff(send_xoff)
  );
endmodule

// File: rtl/flow_ctl_chk.sv
module flow_ctl_chk #(
  parameter int W     = 8,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             auto_rts_en,
  input logic             sw_flow_en,
  input logic             cts_int_en,
  input logic [W-1:0]     xoff1,
  input logic [W-1:0]     rx_byte,
  input logic             rx_valid,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] rx_trigger,
  input logic             tx_busy,
  input logic             tx_char_done,
  input logic             cts_n,
  input logic             tx_allow,
  input logic             rts_ready,
  input logic             send_xon,
  input logic             send_xoff,
  input logic             rx_store,
  input logic             cts_irq,
  input logic             spec_irq
);
  AST_TX_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_allow) |-> $past(!tx_busy || tx_char_done)); // R1
  AST_CTS_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cts_irq |-> $past(cts_n && cts_int_en)); // R3
  AST_FLOW_CODE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && sw_flow_en && rx_byte == xoff1) |=> !rx_store); // R5
  AST_MARKER_STORED: assert property (@(posedge clk) disable iff (rst)
    spec_irq |-> rx_store); // R6
  AST_RTS_DROP_AT_TRIG: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en && rx_count >= rx_trigger) |=> !rts_ready); // R8
  AST_NO_DUAL_REQUEST: assert property (@(posedge clk) disable iff (rst)
    !(send_xon && send_xoff)); // R9
endmodule

bind flow_ctl flow_ctl_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .auto_rts_en(auto_rts_en), .sw_flow_en(sw_flow_en),
  .cts_int_en(cts_int_en), .xoff1(xoff1), .rx_byte(rx_byte), .rx_valid(rx_valid),
  .rx_count(rx_count), .rx_trigger(rx_trigger), .tx_busy(tx_busy),
  .tx_char_done(tx_char_done), .cts_n(cts_n), .tx_allow(tx_allow),
  .rts_ready(rts_ready), .send_xon(send_xon), .send_xoff(send_xoff),
  .rx_store(rx_store), .cts_irq(cts_irq), .spec_irq(spec_irq)
);

// File: tb/tb_flow_ctl.sv
module tb_flow_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       auto_rts_en = 0, auto_cts_en = 0, sw_flow_en = 0, spec_char_en = 0, cts_int_en = 0;
  logic [7:0] xon1 = 8'h11, xon2 = 8'h91, xoff1 = 8'h13, xoff2 = 8'h93;
  logic [7:0] rx_byte = '0;
  logic       rx_valid = 0;
  logic [5:0] rx_count = '0, rx_trigger = 6'd8;
  logic       tx_busy = 0, tx_char_done = 0, cts_n = 0;
  logic       tx_allow, rts_ready, send_xon, send_xoff, rx_store, cts_irq, spec_irq;
  logic [7:0] rx_store_data;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  flow_ctl dut (
    .clk(clk), .rst(rst), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .sw_flow_en(sw_flow_en), .spec_char_en(spec_char_en), .cts_int_en(cts_int_en),
    .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_count(rx_count), .rx_trigger(rx_trigger),
    .tx_busy(tx_busy), .tx_char_done(tx_char_done), .cts_n(cts_n),
    .tx_allow(tx_allow), .rts_ready(rts_ready), .send_xon(send_xon),
    .send_xoff(send_xoff), .rx_store(rx_store), .rx_store_data(rx_store_data),
    .cts_irq(cts_irq), .spec_irq(spec_irq)
  );

  // {byte, sw_flow_en, spec_char_en, exp_store, exp_spec, exp_allow}
  localparam logic [12:0] VEC [10] = '{
    {8'h41, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h13, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h42, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h91, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h93, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h93, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h13, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h93, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    // R10 reset state
    chk("R10 tx_allow", {7'd0, tx_allow}, 8'd1);
    chk("R10 rts_ready", {7'd0, rts_ready}, 8'd1);
    chk("R10 pulses", {3'd0, send_xon, send_xoff, rx_store, cts_irq, spec_irq}, 8'd0);

    // Vector walk: R4 R5 R6 R7 R11
    foreach (VEC[i]) begin
      rx_byte = VEC[i][12:5]; sw_flow_en = VEC[i][4]; spec_char_en = VEC[i][3];
      rx_valid = 1;
      tick();
      rx_valid = 0;
      chk($sformatf("R5 store vec%0d", i), {7'd0, rx_store}, {7'd0, VEC[i][2]});
      if (VEC[i][2]) chk($sformatf("R5 data vec%0d", i), rx_store_data, VEC[i][12:5]);
      chk($sformatf("R6 spec vec%0d", i), {7'd0, spec_irq}, {7'd0, VEC[i][1]});
      chk($sformatf("R4 R7 allow vec%0d", i), {7'd0, tx_allow}, {7'd0, VEC[i][0]});
    end
    spec_char_en = 0;

    // R1 R3: CTS rise on a busy transmitter
    auto_cts_en = 1; cts_int_en = 1; tx_busy = 1; cts_n = 1;
    tick();
    chk("R3 irq pulse", {7'd0, cts_irq}, 8'd1);
    chk("R1 hold while busy", {7'd0, tx_allow}, 8'd1);
    tick();
    chk("R3 irq one cycle", {7'd0, cts_irq}, 8'd0);
    chk("R1 still open", {7'd0, tx_allow}, 8'd1);
    tx_char_done = 1;
    tick();
    tx_char_done = 0;
    chk("R1 stop at boundary", {7'd0, tx_allow}, 8'd0);
    // R2 release
    cts_n = 0;
    tick();
    chk("R2 resume", {7'd0, tx_allow}, 8'd1);
    // R3 disabled
    cts_int_en = 0; cts_n = 1;
    tick();
    chk("R3 masked", {7'd0, cts_irq}, 8'd0);
    cts_n = 0; auto_cts_en = 0;
    tick();

    // R4: stop code in same cycle as char done
    sw_flow_en = 1; rx_byte = 8'h13; rx_valid = 1; tx_char_done = 1;
    tick();
    rx_valid = 0; tx_char_done = 0;
    chk("R4 same-cycle halt", {7'd0, tx_allow}, 8'd0);
    // R11 release by disabling
    sw_flow_en = 0;
    tick();
    chk("R11 release", {7'd0, tx_allow}, 8'd1);
    tx_busy = 0;

    // R8 R9 level watch, trigger 8, resume below 4
    auto_rts_en = 1; sw_flow_en = 1; rx_count = 7;
    tick();
    chk("R8 below trig", {7'd0, rts_ready}, 8'd1);
    chk("R9 no req", {6'd0, send_xon, send_xoff}, 8'd0);
    rx_count = 8;
    tick();
    chk("R8 at trig", {7'd0, rts_ready}, 8'd0);
    chk("R9 xoff req", {6'd0, send_xon, send_xoff}, 8'd1);
    rx_count = 9;
    tick();
    chk("R9 xoff once", {6'd0, send_xon, send_xoff}, 8'd0);
    rx_count = 4;
    tick();
    chk("R8 hysteresis", {7'd0, rts_ready}, 8'd0);
    chk("R9 no early xon", {6'd0, send_xon, send_xoff}, 8'd0);
    rx_count = 3;
    tick();
    chk("R8 reassert", {7'd0, rts_ready}, 8'd1);
    chk("R9 xon req", {6'd0, send_xon, send_xoff}, 8'd2);
    tick();
    chk("R9 xon once", {6'd0, send_xon, send_xoff}, 8'd0);
    auto_rts_en = 0; rx_count = 20;
    tick();
    chk("R8 disabled", {7'd0, rts_ready}, 8'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule